// File: doc/BRIEF.md
# Source Operand Resolver

This block works out the source operand of one instruction. A start pulse brings in five things: the two-bit source addressing mode, the source register number, that register's current value, the byte/word flag and the extension word that follows the instruction. The block then takes one of three paths. It can pass the register value straight through. It can issue a single memory read and return the data that comes back. It can produce a hardwired constant without touching memory.

Two register numbers are decoded in a special way. The zero/constant register always yields a constant. The status register gives its own value in direct mode, uses the extension word as an absolute address in indexed mode, and yields a constant in the two indirect modes. In the post-increment mode the block also returns the step and the incremented register value. The destination stage and the register file take that value, so a destination that names the same register sees the incremented value.

Memory access uses a request/acknowledge handshake. The request and address stay up until the acknowledge arrives. The result appears with a single-cycle `done_o` pulse.

Top module: `src_resolve`

## Requirements
- R1: Mode 0 on any register other than 2 or 3 makes no memory request and returns the register value. `done_o` is high on the cycle after the start edge and `kind_o` = 0 (register).
- R2: Mode 1 on a general register reads memory at register value plus extension word, modulo 2^16. This includes register 0, which gives program-relative access. The read data is returned with `kind_o` = 1 (memory).
- R3: Mode 2 reads memory at the register value and returns the read data.
- R4: Mode 3 reads memory at the register value. At `done_o` it raises `wb_en_o` and drives `wb_val_o` = register value + step. `wb_en_o` is never high outside `done_o`.
- R5: The post-increment step is 1 for byte operations (`byte_i`=1) and 2 for word operations. On register 1 (stack pointer) the step is always 2. `step_o` holds the step while `wb_en_o` is high.
- R6: On register 2, mode 0 returns the register value and mode 1 reads memory at the extension word itself. Mode 2 returns constant 4 and mode 3 returns constant 8.
- R7: On register 3, modes 0, 1, 2 and 3 return the constants 0x0000, 0x0001, 0x0002 and 0xFFFF.
- R8: A constant result has `kind_o` = 2 (constant). It makes no memory request and never raises `wb_en_o`, not even in mode 3.
- R9: For a byte operation, memory read data is zero-extended from its low 8 bits. Register values and constants are returned at full width.
- R10: While a read is waiting, `mem_req_o` stays high and `mem_addr_o` stays stable until `mem_ack_i`. `done_o` pulses on the cycle after the acknowledge edge and `mem_req_o` then drops.
- R11: A start pulse that arrives while a read is outstanding (`busy_o` high) is ignored.
- R12: During and right after reset, `done_o`, `mem_req_o`, `busy_o` and `wb_en_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin resolving with the inputs below |
| mode_i | input | 2 | Source addressing mode |
| sreg_i | input | 4 | Source register number |
| reg_val_i | input | 16 | Current value of the source register |
| byte_i | input | 1 | 1 = byte operation, 0 = word |
| ext_i | input | 16 | Extension word for indexed/absolute mode |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 16 | Memory read address |
| mem_ack_i | input | 1 | Read data valid this cycle |
| mem_rdata_i | input | 16 | Read data |
| busy_o | output | 1 | Read outstanding |
| done_o | output | 1 | Result valid (one cycle) |
| kind_o | output | 2 | 0 register, 1 memory, 2 constant |
| operand_o | output | 16 | Resolved operand |
| step_o | output | 2 | Post-increment step |
| wb_en_o | output | 1 | Write incremented value back to register |
| wb_val_o | output | 16 | Incremented register value |

## Verification
The bench checks both special registers in all four modes. A decoder that treated register 2's indirect modes as memory reads would raise a request where a constant is due. One that missed absolute mode would add the status value to the address. It checks a stack-pointer increment in byte mode, where a design that ignores the register number would step by 1. It also checks program-relative indexing with an address that wraps past 0xFFFF. Byte reads with set upper bits expose missing zero-extension. A start pulse held during an outstanding read would, if not blocked, move the address or replace the returned data.

// File: rtl/src_resolve_pkg.sv
package src_resolve_pkg;

   typedef enum logic [1:0] {
      SRC_REG   = 2'd0,
      SRC_MEM   = 2'd1,
      SRC_CONST = 2'd2
   } src_kind_e;

   typedef enum logic [1:0] {
      AM_REG = 2'd0,
      AM_IDX = 2'd1,
      AM_IND = 2'd2,
      AM_INC = 2'd3
   } am_e;

endpackage

// File: rtl/src_decode.sv
module src_decode
   import src_resolve_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int RIDX_W = 4,
   parameter int SP_IDX = 1,
   parameter int SR_IDX = 2,
   parameter int CG_IDX = 3
) (
   input  logic [1:0]        mode_i,
   input  logic [RIDX_W-1:0] ridx_i,
   input  logic [DATA_W-1:0] reg_val_i,
   input  logic              byte_i,
   input  logic [DATA_W-1:0] ext_i,
   output src_kind_e         kind_o,
   output logic [DATA_W-1:0] addr_o,
   output logic [DATA_W-1:0] value_o,
   output logic [1:0]        step_o,
   output logic              wb_en_o,
   output logic [DATA_W-1:0] wb_val_o
);

   localparam logic [RIDX_W-1:0] SP_R = RIDX_W'(SP_IDX);
   localparam logic [RIDX_W-1:0] SR_R = RIDX_W'(SR_IDX);
   localparam logic [RIDX_W-1:0] CG_R = RIDX_W'(CG_IDX);

   logic is_sp, is_sr, is_cg;

   assign is_sp = (ridx_i == SP_R);
   assign is_sr = (ridx_i == SR_R);
   assign is_cg = (ridx_i == CG_R);

   // step: byte -> 1 except on the stack pointer
   assign step_o   = (byte_i && !is_sp) ? 2'd1 : 2'd2;
   assign wb_val_o = reg_val_i + {{(DATA_W-2){1'b0}}, step_o};

   always_comb begin
      kind_o  = SRC_REG;
      addr_o  = reg_val_i;
      value_o = reg_val_i;
      wb_en_o = 1'b0;
      if (is_cg) begin
         kind_o = SRC_CONST;
         unique case (am_e'(mode_i))
            AM_REG:  value_o = '0;
            AM_IDX:  value_o = DATA_W'(1);
            AM_IND:  value_o = DATA_W'(2);
            default: value_o = '1;
         endcase
      end else if (is_sr && mode_i[1]) begin
         kind_o  = SRC_CONST;
         value_o = mode_i[0] ? DATA_W'(8) : DATA_W'(4);
      end else begin
         unique case (am_e'(mode_i))
            AM_REG: kind_o = SRC_REG;
            AM_IDX: begin
               kind_o = SRC_MEM;
               addr_o = is_sr ? ext_i : (reg_val_i + ext_i);
            end
            AM_IND: kind_o = SRC_MEM;
            default: begin
               kind_o  = SRC_MEM;
               wb_en_o = 1'b1;
            end
         endcase
      end
   end

endmodule

// File: rtl/src_fetch.sv
module src_fetch
   import src_resolve_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  src_kind_e         dec_kind_i,
   input  logic [DATA_W-1:0] dec_addr_i,
   input  logic [DATA_W-1:0] dec_value_i,
   input  logic [1:0]        dec_step_i,
   input  logic              dec_wb_en_i,
   input  logic [DATA_W-1:0] dec_wb_val_i,
   input  logic              byte_i,
   input  logic              mem_ack_i,
   input  logic [DATA_W-1:0] mem_rdata_i,
   output logic              mem_req_o,
   output logic [DATA_W-1:0] mem_addr_o,
   output logic              busy_o,
   output logic              done_o,
   output logic [1:0]        kind_o,
   output logic [DATA_W-1:0] operand_o,
   output logic [1:0]        step_o,
   output logic              wb_en_o,
   output logic [DATA_W-1:0] wb_val_o
);

   typedef enum logic {ST_IDLE, ST_FETCH} st_e;

   st_e               state_q;
   logic              done_q, wb_q, byte_q;
   logic [1:0]        kind_q, step_q;
   logic [DATA_W-1:0] addr_q, oper_q, wbv_q, rd_fmt;

   generate
      if (DATA_W > BYTE_W) begin : g_zext
         assign rd_fmt = byte_q ? {{(DATA_W-BYTE_W){1'b0}}, mem_rdata_i[BYTE_W-1:0]}
                                : mem_rdata_i;
      end else begin : g_pass
         assign rd_fmt = mem_rdata_i;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         done_q  <= 1'b0;
         wb_q    <= 1'b0;
         byte_q  <= 1'b0;
         kind_q  <= SRC_REG;
         step_q  <= 2'd0;
         addr_q  <= '0;
         oper_q  <= '0;
         wbv_q   <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (start_i) begin
               kind_q <= dec_kind_i;
               step_q <= dec_step_i;
               wb_q   <= dec_wb_en_i;
               wbv_q  <= dec_wb_val_i;
               byte_q <= byte_i;
               if (dec_kind_i == SRC_MEM) begin
                  addr_q  <= dec_addr_i;
                  state_q <= ST_FETCH;
               end else begin
                  oper_q <= dec_value_i;
                  done_q <= 1'b1;
               end
            end
            default: if (mem_ack_i) begin
               oper_q  <= rd_fmt;
               done_q  <= 1'b1;
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

   assign mem_req_o  = (state_q == ST_FETCH);
   assign busy_o     = (state_q == ST_FETCH);
   assign mem_addr_o = addr_q;
   assign done_o     = done_q;
   assign kind_o     = kind_q;
   assign operand_o  = oper_q;
   assign step_o     = step_q;
   assign wb_en_o    = done_q & wb_q;
   assign wb_val_o   = wbv_q;

endmodule

// File: rtl/src_resolve.sv
module src_resolve
   import src_resolve_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int RIDX_W = 4,
   parameter int BYTE_W = 8,
   parameter int SP_IDX = 1,
   parameter int SR_IDX = 2,
   parameter int CG_IDX = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [1:0]        mode_i,
   input  logic [RIDX_W-1:0] sreg_i,
   input  logic [DATA_W-1:0] reg_val_i,
   input  logic              byte_i,
   input  logic [DATA_W-1:0] ext_i,
   output logic              mem_req_o,
   output logic [DATA_W-1:0] mem_addr_o,
   input  logic              mem_ack_i,
   input  logic [DATA_W-1:0] mem_rdata_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [1:0]        kind_o,
   output logic [DATA_W-1:0] operand_o,
   output logic [1:0]        step_o,
   output logic              wb_en_o,
   output logic [DATA_W-1:0] wb_val_o
);

   localparam int NREGS = 1 << RIDX_W;

   generate
      if (DATA_W < BYTE_W || DATA_W < 4) begin : g_bad_width
         $error("src_resolve: DATA_W too small");
      end
      if (SP_IDX >= NREGS || SR_IDX >= NREGS || CG_IDX >= NREGS) begin : g_bad_idx
         $error("src_resolve: register index out of range");
      end
      if (SR_IDX == CG_IDX) begin : g_bad_alias
         $error("src_resolve: status and constant register must differ");
      end
   endgenerate

   src_kind_e         d_kind;
   logic [DATA_W-1:0] d_addr, d_value, d_wbv;
   logic [1:0]        d_step;
   logic              d_wb;

   src_decode #(
      .DATA_W(DATA_W), .RIDX_W(RIDX_W),
      .SP_IDX(SP_IDX), .SR_IDX(SR_IDX), .CG_IDX(CG_IDX)
   ) u_dec (
      .mode_i   (mode_i),
      .ridx_i   (sreg_i),
      .reg_val_i(reg_val_i),
      .byte_i   (byte_i),
      .ext_i    (ext_i),
      .kind_o   (d_kind),
      .addr_o   (d_addr),
      .value_o  (d_value),
      .step_o   (d_step),
      .wb_en_o  (d_wb),
      .wb_val_o (d_wbv)
   );

   src_fetch #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_fetch (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .dec_kind_i  (d_kind),
      .dec_addr_i  (d_addr),
      .dec_value_i (d_value),
      .dec_step_i  (d_step),
      .dec_wb_en_i (d_wb),
      .dec_wb_val_i(d_wbv),
      .byte_i      (byte_i),
      .mem_ack_i   (mem_ack_i),
      .mem_rdata_i (mem_rdata_i),
      .mem_req_o   (mem_req_o),
      .mem_addr_o  (mem_addr_o),
      .busy_o      (busy_o),
      .done_o      (done_o),
      .kind_o      (kind_o),
      .operand_o   (operand_o),
      .step_o      (step_o),
      .wb_en_o     (wb_en_o),
      .wb_val_o    (wb_val_o)
   );

endmodule

// File: rtl/src_resolve_chk.sv
module src_resolve_chk #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_req_o,
   input logic              mem_ack_i,
   input logic [DATA_W-1:0] mem_addr_o,
   input logic              done_o,
   input logic [1:0]        kind_o,
   input logic              wb_en_o,
   input logic [1:0]        step_o
);

   // R10: request and address hold until acknowledged
   a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

   // R10: acknowledge yields a memory result next cycle and drops the request
   a_r10_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && mem_ack_i) |=> (done_o && kind_o == 2'd1 && !mem_req_o));

   // R11: no result while a read is still outstanding
   a_r11_no_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_ack_i) |=> !done_o);

   // R8: a constant never writes back
   a_r8_const_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && kind_o == 2'd2) |-> !wb_en_o);

   // R4: write-back only alongside a memory result
   a_r4_wb_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en_o |-> (done_o && kind_o == 2'd1));

   // R5: step is 1 or 2 on write-back
   a_r5_step_legal: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en_o |-> (step_o == 2'd1 || step_o == 2'd2));

   // R12: no request or result on the cycle after reset
   a_r12_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> (!mem_req_o && !done_o && !wb_en_o));

endmodule

bind src_resolve src_resolve_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mem_req_o (mem_req_o),
   .mem_ack_i (mem_ack_i),
   .mem_addr_o(mem_addr_o),
   .done_o    (done_o),
   .kind_o    (kind_o),
   .wb_en_o   (wb_en_o),
   .step_o    (step_o)
);

// File: tb/src_resolve_bench.sv
module src_resolve_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [1:0]  mode_i = '0;
   logic [3:0]  sreg_i = '0;
   logic [15:0] reg_val_i = '0;
   logic        byte_i = 1'b0;
   logic [15:0] ext_i = '0;
   logic        mem_ack_i = 1'b0;
   logic [15:0] mem_rdata_i = '0;
   logic        mem_req_o, busy_o, done_o, wb_en_o;
   logic [15:0] mem_addr_o, operand_o, wb_val_o;
   logic [1:0]  kind_o, step_o;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   src_resolve u_src_resolve (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
      .sreg_i(sreg_i), .reg_val_i(reg_val_i), .byte_i(byte_i), .ext_i(ext_i),
      .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_ack_i(mem_ack_i),
      .mem_rdata_i(mem_rdata_i), .busy_o(busy_o), .done_o(done_o),
      .kind_o(kind_o), .operand_o(operand_o), .step_o(step_o),
      .wb_en_o(wb_en_o), .wb_val_o(wb_val_o)
   );

   localparam logic [1:0] K_REG = 2'd0, K_MEM = 2'd1, K_CON = 2'd2;

   typedef struct packed {
      logic [1:0]  mode;
      logic [3:0]  ridx;
      logic [15:0] val;
      logic        bw;
      logic [15:0] ext;
      logic [15:0] rdata;
      logic [1:0]  ekind;
      logic [15:0] eaddr;
      logic [15:0] eop;
      logic        ewb;
      logic [15:0] ewbv;
      logic [1:0]  estep;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VECS [0:NV-1] = '{
      // R1 direct general register
      '{2'd0, 4'd5, 16'h1234, 1'b0, 16'h0000, 16'h0000, K_REG, 16'h0000, 16'h1234, 1'b0, 16'h0000, 2'd0, 4'd1},
      // R2 indexed, and program-relative with wrap
      '{2'd1, 4'd5, 16'h1000, 1'b0, 16'h0020, 16'hBEEF, K_MEM, 16'h1020, 16'hBEEF, 1'b0, 16'h0000, 2'd0, 4'd2},
      '{2'd1, 4'd0, 16'hFFF0, 1'b0, 16'h0014, 16'h0A0A, K_MEM, 16'h0004, 16'h0A0A, 1'b0, 16'h0000, 2'd0, 4'd2},
      // R3 indirect
      '{2'd2, 4'd7, 16'h2000, 1'b0, 16'h0000, 16'h1111, K_MEM, 16'h2000, 16'h1111, 1'b0, 16'h0000, 2'd0, 4'd3},
      // R4 increment word; R5 byte step and stack pointer step
      '{2'd3, 4'd7, 16'h2000, 1'b0, 16'h0000, 16'h2222, K_MEM, 16'h2000, 16'h2222, 1'b1, 16'h2002, 2'd2, 4'd4},
      '{2'd3, 4'd7, 16'h2000, 1'b1, 16'h0000, 16'h12AB, K_MEM, 16'h2000, 16'h00AB, 1'b1, 16'h2001, 2'd1, 4'd5},
      '{2'd3, 4'd1, 16'h3000, 1'b1, 16'h0000, 16'h5566, K_MEM, 16'h3000, 16'h0066, 1'b1, 16'h3002, 2'd2, 4'd5},
      // R6 status register in all modes
      '{2'd0, 4'd2, 16'h0107, 1'b0, 16'h0000, 16'h0000, K_REG, 16'h0000, 16'h0107, 1'b0, 16'h0000, 2'd0, 4'd6},
      '{2'd1, 4'd2, 16'h9999, 1'b0, 16'h0200, 16'h7777, K_MEM, 16'h0200, 16'h7777, 1'b0, 16'h0000, 2'd0, 4'd6},
      '{2'd2, 4'd2, 16'h9999, 1'b0, 16'h0000, 16'h0000, K_CON, 16'h0000, 16'h0004, 1'b0, 16'h0000, 2'd0, 4'd6},
      '{2'd3, 4'd2, 16'h9999, 1'b0, 16'h0000, 16'h0000, K_CON, 16'h0000, 16'h0008, 1'b0, 16'h0000, 2'd0, 4'd6},
      // R7 constant register in all modes (R8 no request / write-back)
      '{2'd0, 4'd3, 16'h5555, 1'b0, 16'h0000, 16'h0000, K_CON, 16'h0000, 16'h0000, 1'b0, 16'h0000, 2'd0, 4'd7},
      '{2'd1, 4'd3, 16'h5555, 1'b0, 16'h0040, 16'h0000, K_CON, 16'h0000, 16'h0001, 1'b0, 16'h0000, 2'd0, 4'd7},
      '{2'd2, 4'd3, 16'h5555, 1'b0, 16'h0000, 16'h0000, K_CON, 16'h0000, 16'h0002, 1'b0, 16'h0000, 2'd0, 4'd7},
      '{2'd3, 4'd3, 16'h5555, 1'b1, 16'h0000, 16'h0000, K_CON, 16'h0000, 16'hFFFF, 1'b0, 16'h0000, 2'd0, 4'd8},
      // R9 byte read zero-extended
      '{2'd2, 4'd4, 16'h4000, 1'b1, 16'h0000, 16'hABCD, K_MEM, 16'h4000, 16'h00CD, 1'b0, 16'h0000, 2'd0, 4'd9}
   };

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic run_vec(input vec_t v);
      string t;
      t = $sformatf("R%0d", v.req);
      @(negedge clk);
      mode_i = v.mode; sreg_i = v.ridx; reg_val_i = v.val;
      byte_i = v.bw; ext_i = v.ext; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      if (v.ekind == K_MEM) begin
         chk({t, " mem_req"}, {15'd0, mem_req_o}, 16'd1);
         chk({t, " mem_addr"}, mem_addr_o, v.eaddr);
         chk({t, " early done"}, {15'd0, done_o}, 16'd0);
         mem_ack_i = 1'b1; mem_rdata_i = v.rdata;
         @(negedge clk);
         mem_ack_i = 1'b0; mem_rdata_i = 16'h0;
      end else begin
         chk({t, " R8 no request"}, {15'd0, mem_req_o}, 16'd0);
      end
      chk({t, " done"}, {15'd0, done_o}, 16'd1);
      chk({t, " kind"}, {14'd0, kind_o}, {14'd0, v.ekind});
      chk({t, " operand"}, operand_o, v.eop);
      chk({t, " wb_en"}, {15'd0, wb_en_o}, {15'd0, v.ewb});
      if (v.ewb) begin
         chk({t, " wb_val"}, wb_val_o, v.ewbv);
         chk({t, " step"}, {14'd0, step_o}, {14'd0, v.estep});
      end
      @(negedge clk);
      chk({t, " done pulse"}, {15'd0, done_o}, 16'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R12 reset state
      chk("R12 done", {15'd0, done_o}, 16'd0);
      chk("R12 mem_req", {15'd0, mem_req_o}, 16'd0);
      chk("R12 busy", {15'd0, busy_o}, 16'd0);
      chk("R12 wb_en", {15'd0, wb_en_o}, 16'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) run_vec(VECS[i]);

      // R10 / R11: hold request, ignore start while busy
      @(negedge clk);
      mode_i = 2'd2; sreg_i = 4'd6; reg_val_i = 16'h5000; byte_i = 1'b0; start_i = 1'b1;
      @(negedge clk);
      mode_i = 2'd0; sreg_i = 4'd5; reg_val_i = 16'h1111;
      for (int k = 0; k < 3; k++) begin
         chk("R10 req held", {15'd0, mem_req_o}, 16'd1);
         chk("R10 addr stable", mem_addr_o, 16'h5000);
         chk("R11 busy", {15'd0, busy_o}, 16'd1);
         chk("R11 no done", {15'd0, done_o}, 16'd0);
         @(negedge clk);
      end
      start_i = 1'b0;
      mem_ack_i = 1'b1; mem_rdata_i = 16'h3C3C;
      @(negedge clk);
      mem_ack_i = 1'b0;
      chk("R10 done after ack", {15'd0, done_o}, 16'd1);
      chk("R11 operand from read", operand_o, 16'h3C3C);
      chk("R10 req dropped", {15'd0, mem_req_o}, 16'd0);
      @(negedge clk);
      chk("R11 no extra result", {15'd0, done_o}, 16'd0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule